// File: doc/BRIEF.md
# Phase Lock Detector with Selectable Precision

This block decides when a phase-locked loop may be called locked. A fast sampling clock times the error pulses that a phase-frequency detector produces on its up and down outputs. Once in every reference cycle, marked by a single-tick strobe, the block judges the cycle. The cycle is good when the widest error pulse seen since the previous strobe is shorter than a threshold given in fast-clock ticks. The lock flag rises only after a run of consecutive good cycles. That run is three cycles in the short setting and five in the long setting. A single bad cycle ends the run and drops the flag.

The precision setting comes from a 24-bit configuration word. The word is accepted only when its two lowest control bits identify the reference-counter latch. The setting is then taken from bit 18 of the word. A change of setting starts the count again from zero.

Top module: `phase_lock_monitor`

## Requirements
- R1: After synchronous reset, lock is 0 and the short (three-cycle) precision is selected.
- R2: A reference cycle is good only when its widest error pulse, in fast-clock ticks, is strictly below win_thr. A cycle with width equal to win_thr is bad. A cycle with no pulse has width 0.
- R3: With precision 0, lock is 1 in the cycle after the third consecutive good strobe, and not before.
- R4: With precision 1, lock is 1 in the cycle after the fifth consecutive good strobe, and not before.
- R5: A bad strobe clears the run, and lock is 0 in the cycle after it. A new run must then complete in full.
- R6: The run count saturates at its target, so lock stays 1 across any number of further good strobes.
- R7: A cfg_load whose cfg_word[1:0] equals 2'b01 loads the precision from cfg_word[18]. A cfg_load with any other control value has no effect.
- R8: An accepted word that changes the precision clears the run and drops lock. An accepted word that keeps the same precision leaves the run and lock untouched.
- R9: A pulse's width is the count of fast-clock edges at which err_up or err_dn is high. Pulses on either line count the same way, and the widest pulse since the last strobe is the one judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | One-tick marker at the end of each reference cycle |
| err_up | input | 1 | Up error pulse from the phase detector |
| err_dn | input | 1 | Down error pulse from the phase detector |
| win_thr | input | CW | Good-cycle window in fast-clock ticks |
| cfg_load | input | 1 | Configuration word write strobe |
| cfg_word | input | 24 | Configuration word (control bits [1:0], precision bit 18) |
| lock | output | 1 | Registered lock flag |

## Verification
The main sweep covers both precisions and several window sizes. For each combination it applies sequences of reference cycles whose up and down pulse widths step through values on both sides of the window. It also places mixed cycles with pulses on both lines in the same interval. These patterns separate a strict comparison from an inclusive one, show whether a single bad cycle really restarts the run, and show whether the widest pulse, rather than the last one, is judged. Directed sequences add long good runs to show saturation. They also add configuration words with wrong control bits, same-value writes and real precision changes, which show whether a write restarts the count only when it should.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    localparam int CFG_W     = 24;
    localparam int PREC_POS  = 18;
    localparam logic [1:0] CTRL_RCNT = 2'b01;
    localparam int SHORT_RUN = 3;
    localparam int LONG_RUN  = 5;
    localparam int RUN_W     = $clog2(LONG_RUN + 1);

    typedef logic [RUN_W-1:0] run_t;

    typedef enum logic {
        PREC_SHORT = 1'b0,
        PREC_LONG  = 1'b1
    } prec_e;

    typedef struct packed {
        logic valid;
        logic good;
    } verdict_t;

    function automatic run_t run_target(prec_e p);
        return (p == PREC_LONG) ? run_t'(LONG_RUN) : run_t'(SHORT_RUN);
    endfunction
endpackage

// File: rtl/lockdet_cfg.sv
module lockdet_cfg
    import lockdet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    output prec_e            prec,
    output logic             prec_chg
);
    logic  hit;
    prec_e req;

    assign hit      = cfg_load && (cfg_word[1:0] == CTRL_RCNT);
    assign req      = prec_e'(cfg_word[PREC_POS]);
    assign prec_chg = hit && (req != prec);

    always_ff @(posedge clk) begin
        if (rst) begin
            prec <= PREC_SHORT;
        end else if (hit) begin
            prec <= req;
        end
    end

    // R7
    ignore_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_load && cfg_word[1:0] == CTRL_RCNT) |=> $stable(prec));

    // R7
    take_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_word[1:0] == CTRL_RCNT) |=> (prec == prec_e'($past(cfg_word[PREC_POS]))));
endmodule

// File: rtl/lockdet_meter.sv
module lockdet_meter
    import lockdet_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_strobe,
    input  logic          err_up,
    input  logic          err_dn,
    input  logic [CW-1:0] win_thr,
    output verdict_t      verdict
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] peak;
    logic [CW-1:0] width_now;
    logic [CW-1:0] peak_eff;

    assign active = err_up | err_dn;

    always_comb begin
        if (!active)
            width_now = '0;
        else if (cnt == CNT_MAX)
            width_now = CNT_MAX;
        else
            width_now = cnt + 1'b1;
        peak_eff = (width_now > peak) ? width_now : peak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            peak <= '0;
        end else begin
            cnt  <= width_now;
            peak <= ref_strobe ? '0 : peak_eff;
        end
    end

    assign verdict.valid = ref_strobe;
    assign verdict.good  = (peak_eff < win_thr);

    // R9
    pulse_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ref_strobe) |=> (peak != '0));

    // R2
    wide_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_strobe && peak >= win_thr) |-> !verdict.good);
endmodule

// File: rtl/lockdet_run.sv
module lockdet_run
    import lockdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    input  prec_e    prec,
    input  logic     prec_chg,
    output logic     lock,
    output run_t     run
);
    run_t tgt;
    logic reach;

    assign tgt   = run_target(prec);
    assign reach = (run >= tgt) || ((run + 1'b1) >= tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            lock <= 1'b0;
        end else if (prec_chg) begin
            run  <= '0;
            lock <= 1'b0;
        end else if (verdict.valid) begin
            if (verdict.good) begin
                run  <= reach ? tgt : run + 1'b1;
                lock <= reach;
            end else begin
                run  <= '0;
                lock <= 1'b0;
            end
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        run <= tgt);

    // R3
    lock_full_chk: assert property (@(posedge clk) disable iff (rst)
        lock |-> (run == tgt));

    // R5
    bad_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict.valid && !verdict.good) |=> (!lock && run == '0));

    // R8
    prec_restart_chk: assert property (@(posedge clk) disable iff (rst)
        prec_chg |=> (!lock && run == '0));

    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(verdict.valid && verdict.good));
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_strobe,
    input  logic             err_up,
    input  logic             err_dn,
    input  logic [CW-1:0]    win_thr,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             lock
);
    prec_e    prec;
    logic     prec_chg;
    verdict_t verdict;
    run_t     run;

    lockdet_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .prec     (prec),
        .prec_chg (prec_chg)
    );

    lockdet_meter #(.CW(CW)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .ref_strobe (ref_strobe),
        .err_up     (err_up),
        .err_dn     (err_dn),
        .win_thr    (win_thr),
        .verdict    (verdict)
    );

    lockdet_run u_run (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .prec     (prec),
        .prec_chg (prec_chg),
        .lock     (lock),
        .run      (run)
    );
endmodule

// File: tb/sim_phase_lock_monitor.sv
`timescale 1ns/1ps
module sim_phase_lock_monitor;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_strobe = 1'b0;
    logic          err_up = 1'b0;
    logic          err_dn = 1'b0;
    logic [CW-1:0] win_thr = 8'd4;
    logic          cfg_load = 1'b0;
    logic [23:0]   cfg_word = 24'h0;
    logic          lock;

    int checks = 0;
    int errors = 0;
    int m_run  = 0;
    int m_prec = 0;
    bit m_lock = 1'b0;

    always #5 clk = ~clk;

    phase_lock_monitor #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .err_up(err_up),
        .err_dn(err_dn), .win_thr(win_thr), .cfg_load(cfg_load),
        .cfg_word(cfg_word), .lock(lock)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_run = 0; m_prec = 0; m_lock = 1'b0;
        check("R1", lock, 0);
    endtask

    task automatic pulse(input bit on_dn, input int w);
        if (w > 0) begin
            @(negedge clk);
            if (on_dn) err_dn = 1'b1; else err_up = 1'b1;
            repeat (w) @(negedge clk);
            err_up = 1'b0; err_dn = 1'b0;
        end
    endtask

    task automatic ref_cycle(input string tag, input int up_w, input int dn_w);
        int tgt;
        int wmax;
        pulse(1'b0, up_w);
        @(negedge clk);
        pulse(1'b1, dn_w);
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
        tgt  = (m_prec != 0) ? 5 : 3;
        wmax = (up_w > dn_w) ? up_w : dn_w;
        if (wmax < int'(win_thr)) begin
            m_run  = (m_run + 1 > tgt) ? tgt : m_run + 1;
            m_lock = (m_run >= tgt);
        end else begin
            m_run  = 0;
            m_lock = 1'b0;
        end
        check(tag, lock, m_lock);
    endtask

    task automatic cfg_write(input string tag, input logic [23:0] w);
        @(negedge clk) begin cfg_word = w; cfg_load = 1'b1; end
        @(negedge clk) cfg_load = 1'b0;
        if (w[1:0] == 2'b01 && int'(w[18]) != m_prec) begin
            m_prec = w[18];
            m_run = 0;
            m_lock = 1'b0;
        end
        check(tag, lock, m_lock);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, default short precision
        do_reset();
        win_thr = 8'd4;
        // R3: lock only on third good cycle
        ref_cycle("R3", 0, 0);
        check("R3", lock, 0);
        ref_cycle("R3", 3, 0);
        check("R3", lock, 0);
        ref_cycle("R3", 0, 3);
        check("R3", lock, 1);
        // R6: saturation keeps lock
        for (int i = 0; i < 10; i++) ref_cycle("R6", 1, 2);
        check("R6", lock, 1);
        // R2: width equal to window is bad
        ref_cycle("R2", 4, 0);
        check("R2", lock, 0);
        // R5: run must restart in full
        ref_cycle("R5", 0, 0);
        ref_cycle("R5", 0, 0);
        check("R5", lock, 0);
        ref_cycle("R5", 0, 3);
        check("R5", lock, 1);
        // R7: wrong control bits ignored (precision stays short, lock kept)
        cfg_write("R7", 24'h040002);
        check("R7", lock, 1);
        ref_cycle("R7", 5, 0);
        ref_cycle("R7", 0, 0);
        ref_cycle("R7", 0, 0);
        ref_cycle("R7", 0, 0);
        check("R7", lock, 1);
        // R8: same-value write keeps lock
        cfg_write("R8", 24'h000001);
        check("R8", lock, 1);
        // R8: real change to long precision drops lock
        cfg_write("R8", 24'h040001);
        check("R8", lock, 0);
        // R4: five good cycles needed
        for (int i = 0; i < 4; i++) ref_cycle("R4", 2, 1);
        check("R4", lock, 0);
        ref_cycle("R4", 3, 3);
        check("R4", lock, 1);
        // R7: ignored word with bit 18 clear keeps long precision
        cfg_write("R7", 24'h000003);
        check("R7", lock, 1);
        ref_cycle("R7", 4, 0);
        for (int i = 0; i < 3; i++) ref_cycle("R7", 0, 0);
        check("R7", lock, 0);
        ref_cycle("R7", 0, 0);
        ref_cycle("R7", 0, 0);
        check("R7", lock, 1);
        // R8: change back to short precision drops lock
        cfg_write("R8", 24'h000001);
        check("R8", lock, 0);
        // R9: widest pulse judged, on either line
        ref_cycle("R9", 1, 4);
        ref_cycle("R9", 4, 1);
        check("R9", lock, 0);

        // R9 / R2 sweep over precision, window and widths
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 3; t++) begin
                do_reset();
                win_thr = (t == 0) ? 8'd1 : (t == 1) ? 8'd3 : 8'd6;
                cfg_write("R8", (p != 0) ? 24'h040001 : 24'h000001);
                for (int w = 0; w < 8; w++) begin
                    for (int k = 0; k < 6; k++) begin
                        ref_cycle("R9", (w + k) % (int'(win_thr) + 2),
                                  (w * k + 1) % (int'(win_thr) + 2));
                    end
                    for (int k = 0; k < 6; k++) ref_cycle("R2", 0, int'(win_thr) - 1);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule